// File: doc/BRIEF.md
# GPIO Pad Configuration Register Bank

This block holds the pad settings of one eight-pin GPIO port: a weak pull-up enable, a weak pull-down enable, a slew-limit enable and a digital enable for each pin. Software reaches the four registers over a simple synchronous bus. The bus has an address, a write strobe and 32-bit write data. Read data comes back one cycle after the address is presented. The block drives the per-pin pad controls and gates the pin's digital paths. When a pin's digital enable is off, its output enable is forced low and its input is held at zero toward the core.

Pull-up and pull-down exclude each other. Writing a one to a pin in either register clears that pin in the other register on the same clock edge. The register contents pass through a two-stage pipeline on the way to the pads, so a write takes effect at the pads on the second cycle after it. Ports that carry debug pins leave reset with those pins' pull-up and digital enable already on. A per-instance mask parameter selects those pins.

The control path has no multi-cycle sequencing. The only "state" is the decoded register select, an enumeration with five values: none, pull-up, pull-down, slew and digital-enable. A bus cycle moves between them with no history: a mapped address selects its register, and any other address selects none.

Top module: `gpio_padcfg`

## Requirements
- R1: The registers sit at byte offsets 0x510 (pull-up), 0x514 (pull-down), 0x518 (slew limit) and 0x51C (digital enable). Each register holds bits 7:0. A write with `bus_we` high is stored at that clock edge. The value read from an address appears on `bus_rdata` after the next clock edge.
- R2: Bits 31:8 of every register read as zero, and write data in bits 31:8 is discarded.
- R3: Writing the pull-up register stores the data and clears each pull-down bit whose data bit is 1. Pull-down bits whose data bit is 0 are kept.
- R4: Writing the pull-down register stores the data and clears each pull-up bit whose data bit is 1. Pull-up bits whose data bit is 0 are kept.
- R5: For a write stored at clock edge N, the pad controls (`pad_pu_o`, `pad_pd_o`, `pad_den_o`, slew) still show the old setting after edges N and N+1, and show the new one from edge N+2.
- R6: For any pin, `pad_pu_o` and `pad_pd_o` are never high together.
- R7: After reset, pull-down and slew read 0x00, while pull-up and digital enable read the value of the `DBG_MASK` parameter.
- R8: `pad_slew_o[n]` is high only when the delayed slew bit n and `drv8_sel_i[n]` are both high.
- R9: When a pin's delayed digital enable is 0, `pad_oe_o[n]` is 0 whatever `core_oe_i[n]` is, and `core_in_o[n]` is 0 whatever `pad_in_i[n]` is. When it is 1, both pass through.
- R10: An address other than the four offsets reads as zero, and a write to it changes no register.
- R11: Reset is synchronous and active low. It reloads the registers and every pipeline stage, so the pad controls show reset values right after the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| drv8_sel_i | input | 8 | Per-pin 8 mA drive selected |
| core_oe_i | input | 8 | Output enable from the core |
| pad_in_i | input | 8 | Input level from the pad |
| pad_oe_o | output | 8 | Gated output enable to the pad |
| core_in_o | output | 8 | Gated input to the core |
| pad_pu_o | output | 8 | Weak pull-up control |
| pad_pd_o | output | 8 | Weak pull-down control |
| pad_slew_o | output | 8 | Slew-limit control |
| pad_den_o | output | 8 | Digital enable to the pad |

## Verification
The bench writes one pull register while the other has overlapping bits set. A design that did not clear the opposite bit, or that also cleared it when the written bit is zero, reads back the wrong value. The bench samples the pad outputs after each of the two edges that follow a write. A pipeline one stage short shows the new value too early, and a missing reset on a pipeline stage shows stale pulls after a mid-run reset. The bench also writes to unmapped addresses and sets upper data bits, where an address decode that is too loose would corrupt a neighbouring register. A digital enable that is off must block both the output enable and the input even when the core and the pad drive ones.

// File: rtl/padcfg_pkg.sv
package padcfg_pkg;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_PULLUP,
        REG_PULLDN,
        REG_SLEW,
        REG_DIGEN
    } reg_sel_e;

    localparam logic [11:0] OFS_PULLUP = 12'h510;
    localparam logic [11:0] OFS_PULLDN = 12'h514;
    localparam logic [11:0] OFS_SLEW   = 12'h518;
    localparam logic [11:0] OFS_DIGEN  = 12'h51C;

endpackage

// File: rtl/padcfg_regfile.sv
module padcfg_regfile
    import padcfg_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int DATA_W = 32,
    parameter logic [NPINS-1:0] RST_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NPINS-1:0]  pu_q,
    output logic [NPINS-1:0]  pd_q,
    output logic [NPINS-1:0]  slew_q,
    output logic [NPINS-1:0]  den_q
);

    reg_sel_e          sel;
    logic [NPINS-1:0]  wbits;
    logic [DATA_W-1:0] rd_next;

    assign wbits = wdata[NPINS-1:0];

    // address decode: the register select for this bus cycle
    always_comb begin
        unique case (addr)
            OFS_PULLUP: sel = REG_PULLUP;
            OFS_PULLDN: sel = REG_PULLDN;
            OFS_SLEW:   sel = REG_SLEW;
            OFS_DIGEN:  sel = REG_DIGEN;
            default:    sel = REG_NONE;
        endcase
    end

    // register state; pull-up and pull-down clear each other
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pu_q   <= RST_MASK;
            pd_q   <= '0;
            slew_q <= '0;
            den_q  <= RST_MASK;
        end else if (we) begin
            unique case (sel)
                REG_PULLUP: begin
                    pu_q <= wbits;
                    pd_q <= pd_q & ~wbits;
                end
                REG_PULLDN: begin
                    pd_q <= wbits;
                    pu_q <= pu_q & ~wbits;
                end
                REG_SLEW:   slew_q <= wbits;
                REG_DIGEN:  den_q  <= wbits;
                default: ;
            endcase
        end
    end

    // read path
    always_comb begin
        rd_next = '0;
        unique case (sel)
            REG_PULLUP: rd_next[NPINS-1:0] = pu_q;
            REG_PULLDN: rd_next[NPINS-1:0] = pd_q;
            REG_SLEW:   rd_next[NPINS-1:0] = slew_q;
            REG_DIGEN:  rd_next[NPINS-1:0] = den_q;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_next;
    end

    // checks
    assert_pull_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pu_q & pd_q) == '0);

    assert_pu_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFS_PULLUP) |=>
            (pu_q == $past(wbits)) && ((pd_q & $past(wbits)) == '0)
            && ((pd_q & ~$past(wbits)) == ($past(pd_q) & ~$past(wbits))));

    assert_pd_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFS_PULLDN) |=>
            (pd_q == $past(wbits)) && ((pu_q & $past(wbits)) == '0));

    assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == REG_NONE) |=>
            $stable(pu_q) && $stable(pd_q) && $stable(slew_q) && $stable(den_q));

    assert_reset_vals_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |->
            (pu_q == RST_MASK) && (pd_q == '0) && (slew_q == '0) && (den_q == RST_MASK));

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:NPINS] == '0);

endmodule

// File: rtl/padcfg_delay.sv
module padcfg_delay #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];

    // a counter of cycles since reset keeps the past-value check inside its history
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (!rst_n)         warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    if (STAGES == 2) begin : g_chk
        assert_pipe_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (warm >= 2'd2) |-> (q == $past(d, 2)));
    end

    assert_pipe_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (q == RST_VAL));

endmodule

// File: rtl/gpio_padcfg.sv
module gpio_padcfg
    import padcfg_pkg::*;
#(
    parameter int NPINS     = 8,
    parameter int DATA_W    = 32,
    parameter int PAD_DELAY = 2,
    parameter logic [NPINS-1:0] DBG_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  drv8_sel_i,
    input  logic [NPINS-1:0]  core_oe_i,
    input  logic [NPINS-1:0]  pad_in_i,
    output logic [NPINS-1:0]  pad_oe_o,
    output logic [NPINS-1:0]  core_in_o,
    output logic [NPINS-1:0]  pad_pu_o,
    output logic [NPINS-1:0]  pad_pd_o,
    output logic [NPINS-1:0]  pad_slew_o,
    output logic [NPINS-1:0]  pad_den_o
);

    localparam int CW = 4 * NPINS;
    localparam logic [CW-1:0] CTRL_RST = {DBG_MASK, {NPINS{1'b0}}, {NPINS{1'b0}}, DBG_MASK};

    logic [NPINS-1:0] pu_q, pd_q, slew_q, den_q;
    logic [NPINS-1:0] slew_d;
    logic [CW-1:0]    ctrl_now, ctrl_dly;

    padcfg_regfile #(
        .NPINS(NPINS), .DATA_W(DATA_W), .RST_MASK(DBG_MASK)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .addr(bus_addr), .we(bus_we), .wdata(bus_wdata), .rdata(bus_rdata),
        .pu_q(pu_q), .pd_q(pd_q), .slew_q(slew_q), .den_q(den_q)
    );

    assign ctrl_now = {den_q, slew_q, pd_q, pu_q};

    padcfg_delay #(
        .WIDTH(CW), .STAGES(PAD_DELAY), .RST_VAL(CTRL_RST)
    ) u_dly (
        .clk(clk), .rst_n(rst_n), .d(ctrl_now), .q(ctrl_dly)
    );

    assign pad_pu_o   = ctrl_dly[NPINS-1:0];
    assign pad_pd_o   = ctrl_dly[2*NPINS-1:NPINS];
    assign slew_d     = ctrl_dly[3*NPINS-1:2*NPINS];
    assign pad_den_o  = ctrl_dly[4*NPINS-1:3*NPINS];

    assign pad_slew_o = slew_d & drv8_sel_i;
    assign pad_oe_o   = core_oe_i & pad_den_o;
    assign core_in_o  = pad_in_i & pad_den_o;

    assert_pad_pull_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu_o & pad_pd_o) == '0);

    assert_pad_den_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pad_den_o == den_q));

endmodule

// File: tb/gpio_padcfg_test.sv
module gpio_padcfg_test;

    localparam logic [7:0] MASK = 8'h80;
    localparam logic [11:0] A_PU = 12'h510, A_PD = 12'h514, A_SL = 12'h518, A_DE = 12'h51C;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  drv8_sel_i = '0, core_oe_i = '0, pad_in_i = '0;
    logic [7:0]  pad_oe_o, core_in_o, pad_pu_o, pad_pd_o, pad_slew_o, pad_den_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] m_pu, m_pd, m_sl, m_de;

    always #5 clk = ~clk;

    gpio_padcfg #(.DBG_MASK(MASK)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .drv8_sel_i(drv8_sel_i),
        .core_oe_i(core_oe_i), .pad_in_i(pad_in_i), .pad_oe_o(pad_oe_o),
        .core_in_o(core_in_o), .pad_pu_o(pad_pu_o), .pad_pd_o(pad_pd_o),
        .pad_slew_o(pad_slew_o), .pad_den_o(pad_den_o)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_we = 1; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_we = 0;
        case (a)
            A_PU: begin m_pu = d[7:0]; m_pd = m_pd & ~d[7:0]; end
            A_PD: begin m_pd = d[7:0]; m_pu = m_pu & ~d[7:0]; end
            A_SL: m_sl = d[7:0];
            A_DE: m_de = d[7:0];
            default: ;
        endcase
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a; bus_we = 0;
        @(posedge clk); @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic check_regs(input string req);
        logic [31:0] v;
        rd(A_PU, v); check(req, "pull-up reg", v, {24'h0, m_pu});
        rd(A_PD, v); check(req, "pull-down reg", v, {24'h0, m_pd});
        rd(A_SL, v); check(req, "slew reg", v, {24'h0, m_sl});
        rd(A_DE, v); check(req, "digen reg", v, {24'h0, m_de});
    endtask

    task automatic settle;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 0; repeat (3) @(negedge clk); rst_n = 1;
        m_pu = MASK; m_pd = 0; m_sl = 0; m_de = MASK;
        check("R7", "pad pull-up after reset", pad_pu_o, MASK);
        check("R7", "pad pull-down after reset", pad_pd_o, 8'h00);
        check("R7", "pad digen after reset", pad_den_o, MASK);
        check_regs("R7");
    endtask

    task automatic t_readwrite;
        logic [31:0] v;
        wr(A_SL, 32'h5A); rd(A_SL, v); check("R1", "slew readback", v, 32'h5A);
        wr(A_DE, 32'hFF); rd(A_DE, v); check("R1", "digen readback", v, 32'hFF);
    endtask

    task automatic t_upper;
        logic [31:0] v;
        wr(A_PD, 32'hFFFF_FF00); rd(A_PD, v); check("R2", "upper-only write", v, 32'h0);
        wr(A_SL, 32'hABCD_12C3); rd(A_SL, v); check("R2", "upper bits dropped", v, 32'hC3);
    endtask

    task automatic t_pu_clears_pd;
        wr(A_PD, 32'h3C);
        wr(A_PU, 32'h0C);
        check_regs("R3");
        wr(A_PU, 32'h00);
        check_regs("R3");
    endtask

    task automatic t_pd_clears_pu;
        wr(A_PU, 32'hF0);
        wr(A_PD, 32'h81);
        check_regs("R4");
    endtask

    task automatic t_delay;
        logic [7:0] old_pu, old_pd;
        settle;
        old_pu = m_pu; old_pd = m_pd;
        wr(A_PD, 32'h70);
        check("R5", "pull-up after write edge", pad_pu_o, old_pu);
        check("R5", "pull-down after write edge", pad_pd_o, old_pd);
        check("R6", "exclusion edge N", pad_pu_o & pad_pd_o, 8'h0);
        @(negedge clk);
        check("R5", "pull-up after edge N+1", pad_pu_o, old_pu);
        check("R5", "pull-down after edge N+1", pad_pd_o, old_pd);
        check("R6", "exclusion edge N+1", pad_pu_o & pad_pd_o, 8'h0);
        @(negedge clk);
        check("R5", "pull-up after edge N+2", pad_pu_o, m_pu);
        check("R5", "pull-down after edge N+2", pad_pd_o, m_pd);
        check("R6", "exclusion edge N+2", pad_pu_o & pad_pd_o, 8'h0);
        wr(A_PU, 32'hFF);
        for (int i = 0; i < 4; i++) begin
            check("R6", "exclusion after pull-up all", pad_pu_o & pad_pd_o, 8'h0);
            @(negedge clk);
        end
        check("R5", "pull-up settled", pad_pu_o, 8'hFF);
    endtask

    task automatic t_slew;
        settle;
        drv8_sel_i = 8'h0F; #1;
        check("R8", "slew with partial 8mA", pad_slew_o, m_sl & 8'h0F);
        drv8_sel_i = 8'hFF; #1;
        check("R8", "slew with full 8mA", pad_slew_o, m_sl);
        drv8_sel_i = 8'h00; #1;
        check("R8", "slew without 8mA", pad_slew_o, 8'h00);
    endtask

    task automatic t_gate;
        wr(A_DE, 32'h33); settle;
        core_oe_i = 8'hFF; pad_in_i = 8'hFF; #1;
        check("R9", "output enable gated", pad_oe_o, 8'h33);
        check("R9", "input gated", core_in_o, 8'h33);
        core_oe_i = 8'hA5; pad_in_i = 8'h5A; #1;
        check("R9", "output enable pattern", pad_oe_o, 8'hA5 & 8'h33);
        check("R9", "input pattern", core_in_o, 8'h5A & 8'h33);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        wr(12'h50C, 32'hFF); wr(12'h520, 32'hFF); wr(12'h511, 32'hFF);
        rd(12'h50C, v); check("R10", "unmapped read", v, 32'h0);
        check_regs("R10");
    endtask

    task automatic t_midreset;
        settle;
        rst_n = 0; @(negedge clk); rst_n = 1;
        m_pu = MASK; m_pd = 0; m_sl = 0; m_de = MASK;
        check("R11", "pad pull-up right after reset", pad_pu_o, MASK);
        check("R11", "pad pull-down right after reset", pad_pd_o, 8'h00);
        check("R11", "pad digen right after reset", pad_den_o, MASK);
        check_regs("R11");
    endtask

    initial begin
        @(negedge clk);
        t_reset;
        t_readwrite;
        t_upper;
        t_pu_clears_pd;
        t_pd_clears_pu;
        t_delay;
        t_slew;
        t_gate;
        t_unmapped;
        t_midreset;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule